// File: doc/BRIEF.md
# Ring-with-Chords Next-Hop Router

This unit makes the per-hop routing decision for a ring network of 4·N nodes in which every node also has a chord link to the node directly opposite. It is given the identifier of the node holding a flit and the identifier of the flit's destination. From these it works out the distance from the current node to the destination, measured clockwise modulo the node count. It then selects one of four output ports: local delivery, clockwise, counterclockwise or across the chord. It also reports the identifier of the neighbour that will receive the flit and the input port on which the flit will arrive there. Feeding that neighbour identifier back in as the new current node walks the flit to its destination along a shortest path of at most N hops.

Each request is a pair of identifiers carried on a valid/ready stream, and the decision leaves on a second valid/ready stream one cycle after it is accepted. The output is a single register stage. A request is accepted whenever the output register is empty or is being drained in the same cycle, so `in_ready` follows `out_ready` combinationally. While `out_valid` is high and `out_ready` is low, the output holds its contents and no new request is accepted. An identifier equal to or above the node count produces an error result with no port selected.

Top module: `ring_route_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: If the destination equals the current node, `out_port` is 4'b0001 (bit 0, local), `out_next` equals the current node, and `out_arrive` is 4'b0001.
- R3: If the clockwise distance (destination − current) mod 4·N lies in 1..N, `out_port` is 4'b0010 (bit 1, clockwise). `out_next` is (current+1) mod 4·N, and `out_arrive` is 4'b0100 (bit 2, the receiver's counterclockwise-side input).
- R4: If the clockwise distance lies in 3·N..4·N−1, `out_port` is 4'b0100 (bit 2, counterclockwise). `out_next` is (current−1) mod 4·N, and `out_arrive` is 4'b0010 (bit 1, the receiver's clockwise-side input).
- R5: If the clockwise distance lies in N+1..3·N−1, `out_port` is 4'b1000 (bit 3, across). `out_next` is (current+2·N) mod 4·N, and `out_arrive` is 4'b1000 (the receiver's across input).
- R6: If either identifier is 4·N or above, `out_err` is 1 and `out_port`, `out_arrive` and `out_next` are all zero. Otherwise `out_err` is 0 and exactly one bit of `out_port` is set.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, every output field holds its value on the next cycle.
- R8: A request accepted at a clock edge appears on the output right after that edge. An output consumed while no request is offered leaves `out_valid` at 0 after the edge.
- R9: Repeatedly feeding `out_next` back as the current node reaches the destination in at most N hops. For N=4, a flit at node 2 bound for node 12 visits nodes 10, 11 and 12 in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high together with in_valid |
| in_cur | input | IDW | Identifier of the node holding the flit |
| in_dst | input | IDW | Identifier of the flit's destination |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Downstream takes the decision |
| out_port | output | 4 | One-hot output port: bit0 local, bit1 clockwise, bit2 counterclockwise, bit3 across |
| out_next | output | IDW | Identifier of the node receiving the flit |
| out_arrive | output | 4 | One-hot input port at the receiver, same bit meaning as out_port |
| out_err | output | 1 | An identifier was out of range |

## Verification
The bench builds two copies side by side on the same request stream. The first uses N=4: its 16 nodes fill the 4-bit identifier space, so the power-of-two wrap logic is used and the 2→12 example route can be walked. The second uses N=3: its 12 nodes leave identifiers 12 to 15 unused, which exercises the compare-and-correct wrap logic and brings the out-of-range error within reach. With odd N, the boundary distances N, N+1, 3·N−1 and 3·N fall on different bit patterns than in the first copy.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  // bit positions of the one-hot port vectors
  localparam int P_LOC = 0;
  localparam int P_CW  = 1;
  localparam int P_CCW = 2;
  localparam int P_ACR = 3;
  localparam int NPORT = 4;

  typedef logic [NPORT-1:0] portvec_t;

  function automatic portvec_t port_bit(input int idx);
    portvec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/rrt_reldist.sv
module rrt_reldist #(
  parameter int N = 4,
  localparam int NODES = 4 * N,
  localparam int IDW = $clog2(NODES)
) (
  input  logic [IDW-1:0] cur,
  input  logic [IDW-1:0] dst,
  output logic [IDW-1:0] rel,
  output logic           bad
);
  localparam logic [IDW:0] NODES_W = (IDW+1)'(NODES);

  logic [IDW:0] cur_w, dst_w, diff;

  assign cur_w = {1'b0, cur};
  assign dst_w = {1'b0, dst};

  always_comb begin
    if (dst_w >= cur_w) diff = dst_w - cur_w;
    else                diff = dst_w + NODES_W - cur_w;
  end

  assign rel = diff[IDW-1:0];
  assign bad = (cur_w >= NODES_W) || (dst_w >= NODES_W);
endmodule

// File: rtl/rrt_decide.sv
module rrt_decide
  import rrt_pkg::*;
#(
  parameter int N = 4,
  localparam int NODES = 4 * N,
  localparam int IDW = $clog2(NODES)
) (
  input  logic [IDW-1:0] rel,
  input  logic           bad,
  output portvec_t       port
);
  localparam logic [IDW:0] LIM_CW  = (IDW+1)'(N);
  localparam logic [IDW:0] LIM_CCW = (IDW+1)'(3 * N);

  logic [IDW:0] rel_w;
  assign rel_w = {1'b0, rel};

  always_comb begin
    if (bad)                  port = '0;
    else if (rel_w == '0)     port = port_bit(P_LOC);
    else if (rel_w <= LIM_CW) port = port_bit(P_CW);
    else if (rel_w >= LIM_CCW) port = port_bit(P_CCW);
    else                      port = port_bit(P_ACR);
  end
endmodule

// File: rtl/rrt_neighbor.sv
module rrt_neighbor
  import rrt_pkg::*;
#(
  parameter int N = 4,
  localparam int NODES = 4 * N,
  localparam int IDW = $clog2(NODES),
  localparam bit POW2 = ((NODES & (NODES - 1)) == 0)
) (
  input  logic [IDW-1:0] cur,
  input  portvec_t       port,
  output logic [IDW-1:0] next,
  output portvec_t       arrive
);
  localparam logic [IDW-1:0] HALF_ID = IDW'(2 * N);
  localparam logic [IDW-1:0] LAST_ID = IDW'(NODES - 1);
  localparam logic [IDW-1:0] ONE_ID  = IDW'(1);

  logic [IDW-1:0] step_cw, step_ccw, step_acr;

  generate
    if (POW2) begin : g_pow2
      // identifier space is exactly the ring: natural wrap
      assign step_cw  = cur + ONE_ID;
      assign step_ccw = cur - ONE_ID;
      assign step_acr = cur + HALF_ID;
    end else begin : g_gen
      assign step_cw  = (cur == LAST_ID) ? '0 : cur + ONE_ID;
      assign step_ccw = (cur == '0) ? LAST_ID : cur - ONE_ID;
      assign step_acr = (cur >= HALF_ID) ? cur - HALF_ID : cur + HALF_ID;
    end
  endgenerate

  always_comb begin
    next   = '0;
    arrive = '0;
    if (port[P_LOC]) begin
      next   = cur;
      arrive = port_bit(P_LOC);
    end else if (port[P_CW]) begin
      next   = step_cw;
      arrive = port_bit(P_CCW);
    end else if (port[P_CCW]) begin
      next   = step_ccw;
      arrive = port_bit(P_CW);
    end else if (port[P_ACR]) begin
      next   = step_acr;
      arrive = port_bit(P_ACR);
    end
  end
endmodule

// File: rtl/ring_route_unit.sv
module ring_route_unit
  import rrt_pkg::*;
#(
  parameter int N = 4,
  localparam int NODES = 4 * N,
  localparam int IDW = $clog2(NODES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [IDW-1:0] in_cur,
  input  logic [IDW-1:0] in_dst,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [3:0]     out_port,
  output logic [IDW-1:0] out_next,
  output logic [3:0]     out_arrive,
  output logic           out_err
);
  logic [IDW-1:0] rel_c, next_c;
  logic           bad_c;
  portvec_t       port_c, arr_c;

  rrt_reldist #(.N(N)) u_rel (
    .cur (in_cur),
    .dst (in_dst),
    .rel (rel_c),
    .bad (bad_c)
  );

  rrt_decide #(.N(N)) u_dec (
    .rel  (rel_c),
    .bad  (bad_c),
    .port (port_c)
  );

  rrt_neighbor #(.N(N)) u_nbr (
    .cur    (in_cur),
    .port   (port_c),
    .next   (next_c),
    .arrive (arr_c)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_port   <= '0;
      out_next   <= '0;
      out_arrive <= '0;
      out_err    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_port   <= port_c;
        out_next   <= next_c;
        out_arrive <= arr_c;
        out_err    <= bad_c;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_port) && $stable(out_next)
      && $stable(out_arrive) && $stable(out_err)); // R7
  AST_TAKE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R8
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> $countones(out_port) == 1); // R6
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_port == '0 && out_arrive == '0); // R6
  AST_LOCAL_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_port[P_LOC] |-> out_arrive[P_LOC]); // R2
  AST_CW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_port[P_CW] |-> out_arrive[P_CCW]); // R3
  AST_CCW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_port[P_CCW] |-> out_arrive[P_CW]); // R4
  AST_ACR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_port[P_ACR] |-> out_arrive[P_ACR]); // R5
endmodule

// File: tb/ring_route_unit_tb.sv
module ring_route_unit_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, in_valid, out_ready;
  logic [3:0] in_cur, in_dst;

  logic       rdy_a, vld_a, err_a;
  logic [3:0] port_a, next_a, arr_a;
  logic       rdy_b, vld_b, err_b;
  logic [3:0] port_b, next_b, arr_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  ring_route_unit #(.N(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .in_cur(in_cur), .in_dst(in_dst), .out_valid(vld_a), .out_ready(out_ready),
    .out_port(port_a), .out_next(next_a), .out_arrive(arr_a), .out_err(err_a)
  );

  ring_route_unit #(.N(3)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
    .in_cur(in_cur), .in_dst(in_dst), .out_valid(vld_b), .out_ready(out_ready),
    .out_port(port_b), .out_next(next_b), .out_arrive(arr_b), .out_err(err_b)
  );

  // expected {err, port, arrive, next}
  function automatic logic [12:0] model(input int n, input int cur, input int dst);
    int nodes, rel, nx;
    logic [3:0] p, a;
    nodes = 4 * n;
    if (cur >= nodes || dst >= nodes) return {1'b1, 12'd0};
    rel = ((dst - cur) % nodes + nodes) % nodes;
    if (rel == 0)          begin p = 4'b0001; a = 4'b0001; nx = cur; end
    else if (rel <= n)     begin p = 4'b0010; a = 4'b0100; nx = (cur + 1) % nodes; end
    else if (rel >= 3 * n) begin p = 4'b0100; a = 4'b0010; nx = (cur + nodes - 1) % nodes; end
    else                   begin p = 4'b1000; a = 4'b1000; nx = (cur + 2 * n) % nodes; end
    return {1'b0, p, a, 4'(nx)};
  endfunction

  function automatic string tag_of(input logic [12:0] e);
    if (e[12])   return "R6";
    if (e[8])    return "R2";
    if (e[9])    return "R3";
    if (e[10])   return "R4";
    return "R5";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input int cur, input int dst);
    @(negedge clk);
    in_valid = 1'b1;
    out_ready = 1'b1;
    in_cur = 4'(cur);
    in_dst = 4'(dst);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_both(input int cur, input int dst);
    logic [12:0] ea, eb;
    ea = model(4, cur, dst);
    eb = model(3, cur, dst);
    chk({tag_of(ea), " N4 R8 valid"}, 32'(vld_a), 32'd1);
    chk({tag_of(ea), " N4"}, 32'({err_a, port_a, arr_a, next_a}), 32'(ea));
    chk({tag_of(eb), " N3 R8 valid"}, 32'(vld_b), 32'd1);
    chk({tag_of(eb), " N3"}, 32'({err_b, port_b, arr_b, next_b}), 32'(eb));
  endtask

  task automatic route(input int cur, input int dst);
    issue(cur, dst);
    check_both(cur, dst);
  endtask

  // R9 walk on one copy; returns hop count and final node
  task automatic walk(input bit use_b, input int src, input int dst,
                      output int hops, output int last, output int first3);
    int c;
    c = src; hops = 0; first3 = 0;
    for (int k = 0; k < 16; k++) begin
      issue(c, dst);
      if ((use_b ? port_b : port_a) == 4'b0001) break;
      c = int'(use_b ? next_b : next_a);
      if (hops < 3) first3 = (first3 << 4) | c;
      hops++;
    end
    last = c;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h, l, f, seed;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_cur = '0; in_dst = '0;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'({vld_a, vld_b}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'({vld_a, vld_b}), 32'd0);
    chk("R1 ready after reset", 32'({rdy_a, rdy_b}), 32'b11);

    // directed corners: distances 0, N, N+1, 3N-1, 3N, 4N-1 for both sizes
    route(5, 5); route(15, 15); route(0, 0);
    route(2, 6); route(2, 7); route(2, 13); route(2, 14); route(2, 1);
    route(1, 4); route(1, 5); route(1, 9); route(1, 10); route(1, 0);
    route(15, 0); route(0, 15); route(11, 0); route(0, 11);
    route(13, 2); route(2, 13); route(12, 12); route(15, 3);  // R6 for N=3

    // R9 example route for N=4
    walk(1'b0, 2, 12, h, l, f);
    chk("R9 N4 2->12 path", 32'(f), 32'h0000_0ABC);
    chk("R9 N4 2->12 hops", 32'(h), 32'd3);
    chk("R9 N4 2->12 end", 32'(l), 32'd12);

    // constrained random pairs
    for (int i = 0; i < 300; i++) begin
      int c, d;
      c = int'($urandom_range(0, 15));
      d = int'($urandom_range(0, 15));
      route(c, d);
    end

    // R9 random walks
    for (int i = 0; i < 20; i++) begin
      int s, d;
      s = int'($urandom_range(0, 15)); d = int'($urandom_range(0, 15));
      walk(1'b0, s, d, h, l, f);
      chk("R9 N4 reaches", 32'(l), 32'(d));
      chk("R9 N4 hop bound", 32'(h <= 4), 32'd1);
      s = int'($urandom_range(0, 11)); d = int'($urandom_range(0, 11));
      walk(1'b1, s, d, h, l, f);
      chk("R9 N3 reaches", 32'(l), 32'(d));
      chk("R9 N3 hop bound", 32'(h <= 3), 32'd1);
    end

    // back-pressure: R7, R8
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_cur = 4'd3; in_dst = 4'd9;
    @(negedge clk);
    in_cur = 4'd4; in_dst = 4'd4;
    chk("R7 ready low on stall", 32'({rdy_a, rdy_b}), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 hold N4", 32'({vld_a, err_a, port_a, arr_a, next_a}), 32'({1'b1, model(4, 3, 9)}));
      chk("R7 hold N3", 32'({vld_b, err_b, port_b, arr_b, next_b}), 32'({1'b1, model(3, 3, 9)}));
      chk("R7 ready tracks", 32'({rdy_a, rdy_b}), 32'd0);
    end
    out_ready = 1'b1;
    #1;
    chk("R7 ready follows out_ready", 32'({rdy_a, rdy_b}), 32'b11);
    @(negedge clk);
    in_valid = 1'b0;
    check_both(4, 4);
    @(negedge clk);
    chk("R8 drained", 32'({vld_a, vld_b}), 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule